// File: doc/BRIEF.md
# String Operation Sequencer

This block runs block string operations over a byte-addressed memory: move, compare, scan, load and store. A request carries the operation, the operand size (byte or word), a step direction, a repeat kind, an accumulator value, a source and a destination offset, two segment bases and a count. The engine latches the request on a start pulse and then walks through memory over a byte-wide synchronous port. It returns the stepped offsets, the remaining count, the accumulator and three compare flags, and it raises a one-cycle done pulse.

Each physical address is a segment base shifted left by four bits plus an offset. Repetition is driven by the count. Compare and scan can also end early on the equality result. A word is moved as two byte accesses at consecutive addresses, with the low byte at the lower address.

Top module: `strop_engine`

## Requirements
- R1: The source byte address is dseg_in*16 + src offset and the destination byte address is eseg_in*16 + dst offset. Both are truncated to 20 bits, and the offset plus byte index wraps at 16 bits.
- R2: After each pass, every offset in use moves by 1 (byte, wide=0) or 2 (word, wide=1). It increases when dir_dn=0 and decreases when dir_dn=1.
- R3: Operation codes are 0 move, 1 compare, 2 scan, 3 load and 4 store. Scan and store step only the destination offset, load steps only the source offset, and move and compare step both.
- R4: A word access uses address A for the low byte and A+1 for the high byte. Move copies source bytes to destination bytes, and store writes the accumulator. The port never reads and writes in the same cycle.
- R5: Compare checks the source value against the destination value, and scan checks the accumulator (its low byte only when wide=0) against the destination value. Both are unsigned. Less gives cf=1, zf=0, sf=1. Equal gives cf=0, zf=1, sf=0. Greater gives all three flags 0. Move, load and store leave the flags unchanged.
- R6: With rep_kind nonzero, the count is tested before every pass: a zero count makes no memory access and changes no output. Each pass lowers the count by exactly 1, and the count never wraps below zero.
- R7: rep_kind=1 (and 3) repeats compare or scan while zf=1. rep_kind=2 repeats them while zf=0. Each ends earlier if the count reaches zero.
- R8: Move, load and store under any nonzero rep_kind ignore zf and stop only when the count reaches zero.
- R9: With rep_kind=0, exactly one pass runs, whatever the count, and the count is left unchanged.
- R10: After reset, busy, done and both memory strobes are 0. done is a single-cycle pulse at the end of a request. A start pulse while busy is ignored. Operation codes 5 to 7 finish with no memory access.
- R11: A byte load replaces only the accumulator's low byte. A word load replaces all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latches a request when idle |
| op | input | 3 | Operation code |
| wide | input | 1 | 1 = word operand, 0 = byte |
| dir_dn | input | 1 | 1 = offsets decrease |
| rep_kind | input | 2 | 0 none, 1/3 while equal, 2 while not equal |
| acc_in | input | 16 | Initial accumulator |
| src_off_in | input | 16 | Initial source offset |
| dst_off_in | input | 16 | Initial destination offset |
| dseg_in | input | 16 | Source segment base |
| eseg_in | input | 16 | Destination segment base |
| cnt_in | input | 16 | Initial repeat count |
| mem_addr | output | 20 | Byte address |
| mem_rd | output | 1 | Read strobe; data returns next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after mem_rd |
| acc | output | 16 | Accumulator |
| src_off | output | 16 | Source offset |
| dst_off | output | 16 | Destination offset |
| cnt | output | 16 | Remaining count |
| cf | output | 1 | Below flag |
| zf | output | 1 | Equal flag |
| sf | output | 1 | Sign-style flag, set on below |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle that the count only ever drops by one and never wraps below zero, that offsets move only by the size-and-direction step, and that the port stays quiet when idle and never reads and writes at once. They also check that done lasts a single cycle. Which pass a repeat ends on, the flag values, the byte order of words, the address formation with wrap, and the untouched pointer of scan, load and store can only be seen in the bench's scenarios. There, a reference model and directed cases compare outputs, final memory and the number of port accesses.

// File: rtl/strop_engine.sv
module strop_engine #(
  parameter int OFF_W  = 16,
  parameter int PA_W   = 20,
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [2:0]            op,
  input  logic                  wide,
  input  logic                  dir_dn,
  input  logic [1:0]            rep_kind,
  input  logic [2*BYTE_W-1:0]   acc_in,
  input  logic [OFF_W-1:0]      src_off_in,
  input  logic [OFF_W-1:0]      dst_off_in,
  input  logic [OFF_W-1:0]      dseg_in,
  input  logic [OFF_W-1:0]      eseg_in,
  input  logic [OFF_W-1:0]      cnt_in,
  output logic [PA_W-1:0]       mem_addr,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic [BYTE_W-1:0]     mem_wdata,
  input  logic [BYTE_W-1:0]     mem_rdata,
  output logic [2*BYTE_W-1:0]   acc,
  output logic [OFF_W-1:0]      src_off,
  output logic [OFF_W-1:0]      dst_off,
  output logic [OFF_W-1:0]      cnt,
  output logic                  cf,
  output logic                  zf,
  output logic                  sf,
  output logic                  busy,
  output logic                  done
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int SHIFT  = PA_W - OFF_W;
  localparam logic [2:0] OP_MOVE  = 3'd0;
  localparam logic [2:0] OP_CMP   = 3'd1;
  localparam logic [2:0] OP_SCAN  = 3'd2;
  localparam logic [2:0] OP_LOAD  = 3'd3;
  localparam logic [2:0] OP_STORE = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_RSRC, S_RDST, S_WDST, S_LAST, S_STEP, S_DONE
  } st_t;

  st_t               st, first_st;
  logic [2:0]        op_q;
  logic              wide_q, dir_q, bsel;
  logic [1:0]        rep_q;
  logic [OFF_W-1:0]  dseg_q, eseg_q;
  logic [WORD_W-1:0] sbuf, dbuf, lhs, rhs, mask;
  logic [OFF_W-1:0]  step, src_nxt, dst_nxt, src_b, dst_b;
  logic [PA_W-1:0]   src_lin, dst_lin;
  logic              is_cmp, use_src, use_dst, eq, lt, more_byte, stop_zf;

  assign src_b   = src_off + OFF_W'(bsel);
  assign dst_b   = dst_off + OFF_W'(bsel);
  assign src_lin = (PA_W'(dseg_q) << SHIFT) + PA_W'(src_b);
  assign dst_lin = (PA_W'(eseg_q) << SHIFT) + PA_W'(dst_b);

  assign mem_addr  = (st == S_RSRC) ? src_lin : dst_lin;
  assign mem_rd    = (st == S_RSRC) || (st == S_RDST);
  assign mem_wr    = (st == S_WDST);
  assign mem_wdata = (op_q == OP_MOVE) ? mem_rdata
                   : (bsel ? acc[WORD_W-1:BYTE_W] : acc[BYTE_W-1:0]);

  assign is_cmp  = (op_q == OP_CMP) || (op_q == OP_SCAN);
  assign use_src = (op_q == OP_MOVE) || (op_q == OP_CMP) || (op_q == OP_LOAD);
  assign use_dst = (op_q == OP_MOVE) || (op_q == OP_CMP) ||
                   (op_q == OP_SCAN) || (op_q == OP_STORE);

  assign mask    = wide_q ? {WORD_W{1'b1}} : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
  assign lhs     = ((op_q == OP_CMP) ? sbuf : acc) & mask;
  assign rhs     = dbuf & mask;
  assign eq      = (lhs == rhs);
  assign lt      = (lhs < rhs);
  assign stop_zf = is_cmp && ((rep_q == 2'd2) ? eq : !eq);

  assign step    = wide_q ? OFF_W'(2) : OFF_W'(1);
  assign src_nxt = dir_q ? src_off - step : src_off + step;
  assign dst_nxt = dir_q ? dst_off - step : dst_off + step;

  assign more_byte = wide_q && !bsel;
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);

  always_comb begin
    case (op_q)
      OP_SCAN:  first_st = S_RDST;
      OP_STORE: first_st = S_WDST;
      default:  first_st = S_RSRC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= '0;
      wide_q  <= 1'b0;
      dir_q   <= 1'b0;
      rep_q   <= '0;
      dseg_q  <= '0;
      eseg_q  <= '0;
      bsel    <= 1'b0;
      sbuf    <= '0;
      dbuf    <= '0;
      acc     <= '0;
      src_off <= '0;
      dst_off <= '0;
      cnt     <= '0;
      cf      <= 1'b0;
      zf      <= 1'b0;
      sf      <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q    <= op;
          wide_q  <= wide;
          dir_q   <= dir_dn;
          rep_q   <= rep_kind;
          dseg_q  <= dseg_in;
          eseg_q  <= eseg_in;
          acc     <= acc_in;
          src_off <= src_off_in;
          dst_off <= dst_off_in;
          cnt     <= cnt_in;
          st      <= S_CHECK;
        end
        S_CHECK: begin
          bsel <= 1'b0;
          if (op_q > OP_STORE)                   st <= S_DONE;
          else if (rep_q != 2'd0 && cnt == '0)   st <= S_DONE;
          else                                   st <= first_st;
        end
        S_RSRC: begin
          case (op_q)
            OP_MOVE: st <= S_WDST;
            OP_CMP:  st <= S_RDST;
            default: st <= S_LAST;
          endcase
        end
        S_RDST: begin
          if (op_q == OP_CMP) begin
            if (bsel) sbuf[WORD_W-1:BYTE_W] <= mem_rdata;
            else      sbuf[BYTE_W-1:0]      <= mem_rdata;
          end
          st <= S_LAST;
        end
        S_WDST: begin
          if (more_byte) begin bsel <= 1'b1; st <= first_st; end
          else st <= S_STEP;
        end
        S_LAST: begin
          if (op_q == OP_LOAD) begin
            if (bsel) sbuf[WORD_W-1:BYTE_W] <= mem_rdata;
            else      sbuf[BYTE_W-1:0]      <= mem_rdata;
          end else begin
            if (bsel) dbuf[WORD_W-1:BYTE_W] <= mem_rdata;
            else      dbuf[BYTE_W-1:0]      <= mem_rdata;
          end
          if (more_byte) begin bsel <= 1'b1; st <= first_st; end
          else st <= S_STEP;
        end
        S_STEP: begin
          if (is_cmp) begin
            cf <= lt;
            zf <= eq;
            sf <= lt;
          end
          if (op_q == OP_LOAD)
            acc <= wide_q ? sbuf : {acc[WORD_W-1:BYTE_W], sbuf[BYTE_W-1:0]};
          if (use_src) src_off <= src_nxt;
          if (use_dst) dst_off <= dst_nxt;
          if (rep_q != 2'd0) cnt <= cnt - OFF_W'(1);
          st <= (rep_q == 2'd0 || stop_zf) ? S_DONE : S_CHECK;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/strop_engine_chk.sv
module strop_engine_chk #(
  parameter int OFF_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic [OFF_W-1:0] cnt,
  input logic [OFF_W-1:0] src_off,
  input logic [OFF_W-1:0] dst_off,
  input logic             dir_q,
  input logic             wide_q
);
  logic [OFF_W-1:0] stp;
  assign stp = wide_q ? OFF_W'(2) : OFF_W'(1);

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && cnt != $past(cnt)) |-> cnt == $past(cnt) - OFF_W'(1)); // R6
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && $past(cnt) == '0) |-> cnt == '0); // R6
  AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && src_off != $past(src_off)) |->
      src_off == (dir_q ? $past(src_off) - stp : $past(src_off) + stp)); // R2
  AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && dst_off != $past(dst_off)) |->
      dst_off == (dir_q ? $past(dst_off) - stp : $past(dst_off) + stp)); // R2
endmodule

bind strop_engine strop_engine_chk #(.OFF_W(OFF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .cnt(cnt),
  .src_off(src_off), .dst_off(dst_off), .dir_q(dir_q), .wide_q(wide_q)
);

// File: tb/strop_engine_tb_top.sv
module strop_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start = 1'b0, wide = 1'b0, dir_dn = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  rep_kind = '0;
  logic [15:0] acc_in = '0, src_off_in = '0, dst_off_in = '0, dseg_in = '0, eseg_in = '0, cnt_in = '0;
  logic [19:0] mem_addr;
  logic        mem_rd, mem_wr, cf, zf, sf, busy, done;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] acc, src_off, dst_off, cnt;

  strop_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide), .dir_dn(dir_dn),
    .rep_kind(rep_kind), .acc_in(acc_in), .src_off_in(src_off_in), .dst_off_in(dst_off_in),
    .dseg_in(dseg_in), .eseg_in(eseg_in), .cnt_in(cnt_in), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .acc(acc), .src_off(src_off), .dst_off(dst_off), .cnt(cnt),
    .cf(cf), .zf(zf), .sf(sf), .busy(busy), .done(done)
  );

  logic [7:0]  mem [4096];
  logic [7:0]  ref_mem [4096];
  logic        fill_req = 1'b0;
  logic [1:0]  fill_mode = '0;
  int          acc_n;
  logic [19:0] first_addr;
  logic        seen;

  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < 4096; i++) begin
        case (fill_mode)
          2'd0:    mem[i] <= 8'($urandom % 4);
          2'd1:    mem[i] <= 8'h00;
          default: mem[i] <= 8'(i) ^ 8'h3C;
        endcase
      end
      acc_n <= 0;
      seen  <= 1'b0;
    end else begin
      if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
      if (mem_rd || mem_wr) begin
        acc_n <= acc_n + 1;
        if (!seen) first_addr <= mem_addr;
        seen <= 1'b1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  logic [15:0] m_acc, m_so, m_do, m_cnt;
  logic        m_cf = 1'b0, m_zf = 1'b0, m_sf = 1'b0;
  int          m_n;

  function automatic logic [19:0] pa20(input logic [15:0] seg, input logic [15:0] off, input int b);
    logic [15:0] o;
    o = off + 16'(b);
    return {seg, 4'h0} + {4'h0, o};
  endfunction

  function automatic logic [11:0] pa(input logic [15:0] seg, input logic [15:0] off, input int b);
    logic [19:0] a;
    a = pa20(seg, off, b);
    return a[11:0];
  endfunction

  task automatic model(input logic [2:0] mop, input logic w, input logic d, input logic [1:0] rp,
                       input logic [15:0] a, input logic [15:0] so, input logic [15:0] dof,
                       input logic [15:0] ds, input logic [15:0] es, input logic [15:0] c);
    logic [15:0] sv, dv, l, r, stp;
    int nb;
    bit cmpish;
    m_acc = a; m_so = so; m_do = dof; m_cnt = c; m_n = 0;
    nb = w ? 2 : 1;
    stp = w ? 16'd2 : 16'd1;
    cmpish = (mop == 3'd1) || (mop == 3'd2);
    if (mop > 3'd4) return;
    while (1) begin
      if (rp != 2'd0 && m_cnt == 16'd0) break;
      sv = '0; dv = '0;
      for (int b = 0; b < nb; b++) begin
        case (mop)
          3'd0: begin ref_mem[pa(es, m_do, b)] = ref_mem[pa(ds, m_so, b)]; m_n += 2; end
          3'd1: begin sv[8*b +: 8] = ref_mem[pa(ds, m_so, b)]; dv[8*b +: 8] = ref_mem[pa(es, m_do, b)]; m_n += 2; end
          3'd2: begin dv[8*b +: 8] = ref_mem[pa(es, m_do, b)]; m_n += 1; end
          3'd3: begin sv[8*b +: 8] = ref_mem[pa(ds, m_so, b)]; m_n += 1; end
          default: begin ref_mem[pa(es, m_do, b)] = m_acc[8*b +: 8]; m_n += 1; end
        endcase
      end
      if (cmpish) begin
        l = (mop == 3'd1) ? sv : m_acc;
        r = dv;
        if (!w) begin l = {8'h00, l[7:0]}; r = {8'h00, r[7:0]}; end
        m_cf = l < r; m_zf = l == r; m_sf = l < r;
      end
      if (mop == 3'd3) m_acc = w ? sv : {m_acc[15:8], sv[7:0]};
      if (mop != 3'd2 && mop != 3'd4) m_so = d ? m_so - stp : m_so + stp;
      if (mop != 3'd3) m_do = d ? m_do - stp : m_do + stp;
      if (rp != 2'd0) m_cnt = m_cnt - 16'd1;
      if (rp == 2'd0) break;
      if (cmpish && ((rp == 2'd2) ? m_zf : !m_zf)) break;
    end
  endtask

  task automatic run(input logic [2:0] mop, input logic w, input logic d, input logic [1:0] rp,
                     input logic [15:0] a, input logic [15:0] so, input logic [15:0] dof,
                     input logic [15:0] ds, input logic [15:0] es, input logic [15:0] c,
                     input logic [1:0] mode, input bit restart);
    int t;
    int bad;
    @(negedge clk); fill_req = 1'b1; fill_mode = mode;
    @(negedge clk); fill_req = 1'b0;
    for (int i = 0; i < 4096; i++) ref_mem[i] = mem[i];
    op = mop; wide = w; dir_dn = d; rep_kind = rp; acc_in = a;
    src_off_in = so; dst_off_in = dof; dseg_in = ds; eseg_in = es; cnt_in = c;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (restart) begin
      op = 3'd4; wide = 1'b1; acc_in = 16'hFFFF; cnt_in = 16'd9; rep_kind = 2'd1;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (!done && t < 4000) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R10", "done seen", 32'(done), 32'd1);
    model(mop, w, d, rp, a, so, dof, ds, es, c);
    chk(acc == m_acc, "R11", "acc", 32'(acc), 32'(m_acc));
    chk(src_off == m_so, "R2", "src_off", 32'(src_off), 32'(m_so));
    chk(dst_off == m_do, "R3", "dst_off", 32'(dst_off), 32'(m_do));
    chk(cnt == m_cnt, "R6", "cnt", 32'(cnt), 32'(m_cnt));
    chk({cf, zf, sf} == {m_cf, m_zf, m_sf}, "R5", "flags", 32'({cf, zf, sf}), 32'({m_cf, m_zf, m_sf}));
    chk(acc_n == m_n, "R7", "port accesses", 32'(acc_n), 32'(m_n));
    bad = -1;
    for (int i = 0; i < 4096; i++) if (bad < 0 && mem[i] !== ref_mem[i]) bad = i;
    chk(bad < 0, "R4", "memory image mismatch index", 32'(bad), 32'hFFFFFFFF);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr, "R10", "reset idle",
        32'({busy, done, mem_rd, mem_wr}), 32'd0);
    chk(cnt == 16'd0 && acc == 16'd0, "R10", "reset regs", 32'({acc, cnt}), 32'd0);

    // R1 and R11: byte load from 0x12345; value = 0x45 ^ 0x3C
    run(3'd3, 1'b0, 1'b0, 2'd0, 16'hBE00, 16'h0005, 16'h0000, 16'h1234, 16'h0000, 16'd0, 2'd2, 1'b0);
    chk(first_addr == 20'h12345, "R1", "source address", 32'(first_addr), 32'h12345);
    chk(acc == 16'hBE79, "R11", "byte load keeps high byte", 32'(acc), 32'hBE79);

    // R1: destination address wraps at 20 bits
    run(3'd4, 1'b0, 1'b0, 2'd0, 16'h0011, 16'h0000, 16'h0020, 16'h0000, 16'hFFFF, 16'd0, 2'd1, 1'b0);
    chk(first_addr == 20'h00010, "R1", "wrapped dest address", 32'(first_addr), 32'h00010);

    // R4: word store little-endian, decrementing
    run(3'd4, 1'b1, 1'b1, 2'd0, 16'hA55A, 16'h0000, 16'h0100, 16'h0000, 16'h0000, 16'd0, 2'd1, 1'b0);
    chk(mem[12'h100] == 8'h5A && mem[12'h101] == 8'hA5, "R4", "word byte order",
        32'({mem[12'h101], mem[12'h100]}), 32'hA55A);
    chk(dst_off == 16'h00FE, "R2", "word step down", 32'(dst_off), 32'h00FE);

    // R11 / R3: word load, destination untouched
    run(3'd3, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h0200, 16'h0777, 16'h0000, 16'h0000, 16'd0, 2'd2, 1'b0);
    chk(acc == 16'h3D3C, "R11", "word load", 32'(acc), 32'h3D3C);
    chk(dst_off == 16'h0777, "R3", "load leaves dst", 32'(dst_off), 32'h0777);

    // R6: zero count under repeat does nothing
    run(3'd0, 1'b1, 1'b0, 2'd1, 16'h1234, 16'h0300, 16'h0400, 16'h0000, 16'h0000, 16'd0, 2'd0, 1'b0);
    chk(acc_n == 0 && src_off == 16'h0300 && dst_off == 16'h0400, "R6", "zero count idle",
        32'(acc_n), 32'd0);

    // R9: no prefix, one pass, count kept
    run(3'd0, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h0300, 16'h0400, 16'h0000, 16'h0000, 16'd0, 2'd0, 1'b0);
    chk(acc_n == 4 && cnt == 16'd0, "R9", "single pass", 32'(acc_n), 32'd4);

    // R7: while-equal over equal data runs out the count; while-not-equal stops after one
    run(3'd1, 1'b0, 1'b0, 2'd1, 16'h0000, 16'h0010, 16'h0200, 16'h0000, 16'h0000, 16'd5, 2'd1, 1'b0);
    chk(cnt == 16'd0 && zf, "R7", "repeat-equal exhausts", 32'(cnt), 32'd0);
    run(3'd1, 1'b0, 1'b0, 2'd2, 16'h0000, 16'h0010, 16'h0200, 16'h0000, 16'h0000, 16'd5, 2'd1, 1'b0);
    chk(cnt == 16'd4, "R7", "repeat-not-equal stops", 32'(cnt), 32'd4);

    // R8: move ignores zf under while-not-equal
    run(3'd0, 1'b0, 1'b0, 2'd2, 16'h0000, 16'h0010, 16'h0200, 16'h0000, 16'h0000, 16'd3, 2'd1, 1'b0);
    chk(cnt == 16'd0 && acc_n == 6, "R8", "move runs count out", 32'(cnt), 32'd0);

    // R5: scan less (0x01 vs 0x3C) then greater (0x3D vs 0x3C)
    run(3'd2, 1'b0, 1'b0, 2'd0, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'd0, 2'd2, 1'b0);
    chk({cf, zf, sf} == 3'b101, "R5", "scan less", 32'({cf, zf, sf}), 32'b101);
    run(3'd2, 1'b0, 1'b0, 2'd0, 16'hFF3D, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'd0, 2'd2, 1'b0);
    chk({cf, zf, sf} == 3'b000, "R5", "scan greater", 32'({cf, zf, sf}), 32'b000);

    // R10: second start while busy ignored; invalid op makes no access
    run(3'd0, 1'b0, 1'b0, 2'd1, 16'h0000, 16'h0100, 16'h0500, 16'h0000, 16'h0000, 16'd4, 2'd0, 1'b1);
    run(3'd6, 1'b1, 1'b0, 2'd1, 16'h0000, 16'h0100, 16'h0500, 16'h0000, 16'h0000, 16'd4, 2'd0, 1'b0);
    chk(acc_n == 0 && cnt == 16'd4, "R10", "invalid op", 32'(acc_n), 32'd0);

    for (int k = 0; k < 300; k++) begin
      run(3'($urandom % 6), 1'($urandom), 1'($urandom), 2'($urandom),
          {8'($urandom % 4), 8'($urandom % 4)},
          16'(16 + $urandom % 1000), 16'(16 + $urandom % 1000),
          16'($urandom % 64), 16'($urandom % 64), 16'($urandom % 9), 2'd0, 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule